// File: doc/BRIEF.md
# Light-Sensor Command Target on a Two-Wire Serial Bus

This block is the serial-bus target of an ambient-light measurement front end. It watches SCL and SDA, which it samples with the system clock, and it answers one 7-bit address. The upper four bits of that address are fixed at binary 1000, and three strap inputs supply the lower three bits. The block has no register pointer. Each data byte that the bus master writes replaces the single 8-bit command register and sends a one-cycle strobe to the conversion controller. When a write carries only the address byte, the stored command is issued again when the transfer closes.

A read returns a fixed little-endian stream: the result low byte, the result high byte, the integration count low byte and the integration count high byte. The command selects how long the stream is. External-timing commands yield all four bytes, and internal-timing commands yield only the two result bytes. A command with bit 7 set is a loopback test value, and a read then returns that command byte in place of sensor data. The conversion controller delivers results through a completion strobe. The block copies the stored result into a read image when it acknowledges the address byte, so a read never mixes two conversions. SDA is driven only through a pull-low enable.

Top module: `lux_i2c_target`

## Requirements
- R1: The block acknowledges only address {4'b1000, strap[2:0]}. For any other address it leaves SDA released until the next START or STOP, and a data byte that follows does not change the command.
- R2: Each data byte written after a matched address with R/W=0 is acknowledged. It replaces `cmd_q`, and `cmd_strobe` is high for exactly one clock cycle.
- R3: A matched address with R/W=0 that is followed directly by STOP or a repeated START leaves `cmd_q` unchanged and gives one `cmd_strobe` pulse.
- R4: When `cmd_q[7]`=0 and `cmd_q[5:4]`=2'b11 (external timing), a read returns result[7:0], result[15:8], count[7:0], count[15:8] in that order. Each byte is sent MSB first.
- R5: For every other command with `cmd_q[7]`=0 (internal timing), SDA stays released after the second byte of a read, so any further bytes read as 8'hFF.
- R6: When `cmd_q[7]`=1 (loopback), the first two bytes of a read both equal `cmd_q`, and any later bytes read as 8'hFF.
- R7: The read image is captured when the address byte is acknowledged. A `conv_done` that arrives during a read does not change that read, and the next read returns the new values.
- R8: Result and count are stored only on `conv_done`. A read returns the most recently completed values.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START begins a new address phase. The acknowledge occupies the ninth clock.
- R10: When the master does not acknowledge a read byte, SDA stays released for the rest of the transfer.
- R11: After reset `cmd_q`=8'h00, SDA is released and `cmd_strobe` is low.
- R12: `sda_pull` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It must run at least 8 times faster than SCL. |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| strap | input | 3 | Lower three bits of the target address |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_result | input | 16 | Conversion result, captured on `conv_done` |
| conv_count | input | 16 | Integration count, captured on `conv_done` |
| sda_pull | output | 1 | Pull-low enable for SDA |
| cmd_q | output | 8 | Current command byte |
| cmd_strobe | output | 1 | One-cycle pulse that issues a command |

## Verification
A table drives command bytes from each class in turn: internal timing, external timing, difference modes and loopback values. Each entry is paired with result and count words whose bytes all differ, so a byte-order mistake, a wrong stream length or a loopback mix-up each produces a different wrong byte. Directed sequences then cover the remaining cases. They try a foreign address followed by a data byte, and a write that carries only the address. They also try a conversion that completes in the middle of a read followed by a fresh read through a repeated START, and a master NACK followed by extra clocks. Together these separate the snapshot, re-issue and release behaviour from the normal data path.

// File: rtl/lux_i2c_target.sv
module lux_i2c_target #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter logic [3:0] ADDR_HI = 4'b1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [2:0]  strap,
  input  logic        conv_done,
  input  logic [15:0] conv_result,
  input  logic [15:0] conv_count,
  output logic        sda_pull,
  output logic [7:0]  cmd_q,
  output logic        cmd_strobe
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_SKIP
  } state_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0]    scl_h, sda_h;
  logic scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h  <= '1; sda_h  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_p  <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_h  <= {scl_h[FILT_LEN-2:0], scl_sy[SYNC_STAGES-1]};
      sda_h  <= {sda_h[FILT_LEN-2:0], sda_sy[SYNC_STAGES-1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire bus_start = scl_f & scl_p & sda_p & ~sda_f;
  wire bus_stop  = scl_f & scl_p & ~sda_p & sda_f;

  logic [15:0] res_q, cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (conv_done) begin
      res_q <= conv_result;
      cnt_q <= conv_count;
    end
  end

  state_t      state;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg, tx;
  logic [31:0] img;
  logic [1:0]  byte_idx;
  logic        rw, wr_pend, m_nack;

  wire loopback = cmd_q[7];
  wire ext_mode = ~cmd_q[7] & (cmd_q[5:4] == 2'b11);
  wire [2:0] rd_len = ext_mode ? 3'd4 : 3'd2;
  wire addr_hit = (shreg[7:1] == {ADDR_HI, strap});

  logic [2:0] nxt_idx;
  logic [7:0] nxt_b;
  always_comb begin
    nxt_idx = (state == S_RACK) ? ({1'b0, byte_idx} + 3'd1) : 3'd0;
    case (nxt_idx[1:0])
      2'd0:    nxt_b = img[7:0];
      2'd1:    nxt_b = img[15:8];
      2'd2:    nxt_b = img[23:16];
      default: nxt_b = img[31:24];
    endcase
    if (loopback) nxt_b = cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bit_cnt <= '0; shreg <= '0; tx <= '0;
      img <= '0; byte_idx <= '0; rw <= 1'b0; wr_pend <= 1'b0;
      m_nack <= 1'b0; sda_pull <= 1'b0; cmd_q <= 8'h00; cmd_strobe <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      if (bus_start || bus_stop) begin
        if (wr_pend) cmd_strobe <= 1'b1;
        wr_pend  <= 1'b0;
        sda_pull <= 1'b0;
        bit_cnt  <= '0;
        state    <= bus_start ? S_ADDR : S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_f};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == S_WR) begin
                cmd_q      <= shreg;
                cmd_strobe <= 1'b1;
                wr_pend    <= 1'b0;
                sda_pull   <= 1'b1;
                state      <= S_WACK;
              end else if (addr_hit) begin
                sda_pull <= 1'b1;
                rw       <= shreg[0];
                img      <= {cnt_q, res_q};
                wr_pend  <= ~shreg[0];
                state    <= S_AACK;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              byte_idx <= '0;
              tx       <= nxt_b;
              sda_pull <= ~nxt_b[7];
              state    <= S_RD;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_WR;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            state    <= S_WR;
          end
          S_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= S_RACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_nack <= sda_f;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (m_nack || nxt_idx >= rd_len) begin
                state <= S_SKIP;
              end else begin
                byte_idx <= nxt_idx[1:0];
                tx       <= nxt_b;
                sda_pull <= ~nxt_b[7];
                state    <= S_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module lux_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_pull,
  input logic [7:0] cmd_q,
  input logic       cmd_strobe
);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  assert_cmd_change_strobed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != $past(cmd_q)) |-> cmd_strobe);

  assert_pull_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in);

  assert_reset_released_R11: assert property (@(posedge clk)
    !rst_n |-> !sda_pull && !cmd_strobe);

endmodule

bind lux_i2c_target lux_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .cmd_q(cmd_q), .cmd_strobe(cmd_strobe)
);

// File: tb/lux_i2c_target_bench.sv
module lux_i2c_target_bench;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW = {4'b1000, STRAP, 1'b0};
  localparam logic [7:0] AR = {4'b1000, STRAP, 1'b1};
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 16'h1234, 16'h5678},
    {8'h30, 16'hA1B2, 16'h0C3D},
    {8'h04, 16'h9E8F, 16'h7D6C},
    {8'h38, 16'hFFEE, 16'h8001},
    {8'hC3, 16'h4455, 16'h6677},
    {8'h08, 16'h0102, 16'h0304},
    {8'hB5, 16'hCAFE, 16'hBEEF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic conv_done = 1'b0;
  logic [15:0] conv_result = '0, conv_count = '0;
  logic sda_pull, cmd_strobe;
  logic [7:0] cmd_q;
  wire sda_bus = sda_drv & ~sda_pull;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n && cmd_strobe) strobes++;

  lux_i2c_target u_lux_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .strap(STRAP),
    .conv_done(conv_done), .conv_result(conv_result), .conv_count(conv_count),
    .sda_pull(sda_pull), .cmd_q(cmd_q), .cmd_strobe(cmd_strobe)
  );

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; w(Q); scl = 1'b1; w(Q);
    sda_drv = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; w(Q); scl = 1'b1; w(Q); sda_drv = 1'b1; w(2*Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_drv = b; w(Q); scl = 1'b1; w(Q); s = sda_bus; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, ack_n);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); d[i] = s; end
    clock_bit(nack, s);
  endtask

  task automatic conv(logic [15:0] r, logic [15:0] c);
    @(negedge clk); conv_result = r; conv_count = c; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, b;
    logic [7:0] d;
    logic [7:0] exp_b [4];
    int s0;
    w(5); rst_n = 1'b1; w(5);
    chk("R11 cmd after reset", cmd_q, 8'h00);
    chk("R11 sda released", sda_pull, 1'b0);
    chk("R11 no strobe", strobes, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0]  c;
      logic [15:0] r, n;
      c = VEC[v][39:32]; r = VEC[v][31:16]; n = VEC[v][15:0];
      s0 = strobes;
      i2c_start(); wr_byte(AW, a); wr_byte(c, b); i2c_stop();
      chk("R1 address ack", a, 1'b0);
      chk("R2 data ack", b, 1'b0);
      chk("R2 command stored", cmd_q, c);
      chk("R2 one strobe", strobes - s0, 1);
      conv(r, n);
      if (c[7]) begin
        exp_b = '{c, c, 8'hFF, 8'hFF};
      end else if (c[5:4] == 2'b11) begin
        exp_b = '{r[7:0], r[15:8], n[7:0], n[15:8]};
      end else begin
        exp_b = '{r[7:0], r[15:8], 8'hFF, 8'hFF};
      end
      i2c_start(); wr_byte(AR, a);
      chk("R9 read address ack", a, 1'b0);
      for (int k = 0; k < 4; k++) begin
        rd_byte(k == 3, d);
        if (c[7])                     chk("R6 loopback byte", d, exp_b[k]);
        else if (c[5:4] == 2'b11)     chk("R4 external byte order", d, exp_b[k]);
        else if (k < 2)               chk("R8 internal result byte", d, exp_b[k]);
        else                          chk("R5 internal stream ends", d, exp_b[k]);
      end
      i2c_stop();
    end

    s0 = strobes;
    i2c_start(); wr_byte({4'b1000, 3'b100, 1'b0}, a); wr_byte(8'h30, b); i2c_stop();
    chk("R1 foreign address no ack", a, 1'b1);
    chk("R1 foreign data no ack", b, 1'b1);
    chk("R1 command unchanged", cmd_q, 8'hB5);
    chk("R1 no strobe", strobes - s0, 0);

    i2c_start(); wr_byte(AW, a); wr_byte(8'h30, b); i2c_stop();
    s0 = strobes;
    i2c_start(); wr_byte(AW, a); i2c_stop();
    chk("R3 address-only ack", a, 1'b0);
    chk("R3 reissue strobe", strobes - s0, 1);
    chk("R3 command kept", cmd_q, 8'h30);

    conv(16'h1111, 16'h2222);
    i2c_start(); wr_byte(AR, a);
    rd_byte(1'b0, d); chk("R7 first byte old", d, 8'h11);
    conv(16'h3333, 16'h4444);
    rd_byte(1'b0, d); chk("R7 old result high", d, 8'h11);
    rd_byte(1'b0, d); chk("R7 old count low", d, 8'h22);
    rd_byte(1'b1, d); chk("R7 old count high", d, 8'h22);
    i2c_start(); wr_byte(AR, a);
    chk("R9 repeated start ack", a, 1'b0);
    rd_byte(1'b0, d); chk("R7 new result low", d, 8'h33);
    rd_byte(1'b1, d); chk("R7 new result high", d, 8'h33);
    i2c_stop();

    conv(16'h0000, 16'h0000);
    i2c_start(); wr_byte(AR, a);
    rd_byte(1'b1, d); chk("R8 zero result", d, 8'h00);
    rd_byte(1'b1, d); chk("R10 released after nack", d, 8'hFF);
    i2c_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule